// File: doc/BRIEF.md
# Windowed Watchdog Down-Counter

This block is the timing core of a watchdog. A down-counter is loaded with a programmed time-out period and decrements once per clock while the watchdog is enabled. The period has a lower limit of 256 cycles. If software lets the counter run out, the block emits a one-cycle time-out event and starts a new period.

A separate sequence checker watches the key writes. When it sees a complete and correct service sequence, it sends a one-cycle completion pulse, and the counter reloads. The checker also sends a strobe for every service write it receives. When window mode is on, service is allowed only late in the period, while the counter is strictly below the window value. A service write made while the window is closed is reported as an invalid access. A select input decides whether that report goes out as a bus error or as a reset request.

Top module: `wwdg_down_counter`

## Requirements
- R1: The effective period is `timeout_val_i` when that value is 256 or more, and 256 when it is less.
- R2: While enabled, and with no load or time-out in the same cycle, `count_o` decreases by one on each clock.
- R3: When the enabled counter is at 0, the next clock reloads the effective period and raises `timeout_o` for exactly one cycle.
- R4: An accepted service pulse on `svc_done_i` reloads the effective period on the next clock. An accepted pulse is one that arrives while enabled with the window open.
- R5: While `enable_i` is 0, `count_o` holds its value and `timeout_o`, `bus_err_o` and `rst_req_o` stay 0. A 0-to-1 change of `enable_i` loads the effective period.
- R6: With `win_mode_i` = 1, `win_open_o` is 1 exactly when `count_o` < `window_val_i`.
- R7: With `win_mode_i` = 1 and the block enabled, a strobe on `svc_wr_i` while the window is closed gives a one-cycle pulse on the next clock. The pulse is on `bus_err_o` when `resp_sel_i` = 0 and on `rst_req_o` when `resp_sel_i` = 1, and the two outputs are never high together.
- R8: With `win_mode_i` = 1, a `svc_done_i` pulse while the window is closed does not reload the counter, which keeps counting down. A `svc_wr_i` strobe while the window is open raises no error.
- R9: With `win_mode_i` = 0, `win_open_o` is 1 and a `svc_wr_i` strobe never raises `bus_err_o` or `rst_req_o`.
- R10: After reset, `count_o` is 0 and `timeout_o`, `bus_err_o` and `rst_req_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Watchdog enable |
| win_mode_i | input | 1 | Window mode on |
| resp_sel_i | input | 1 | Invalid-access response: 0 = bus error, 1 = reset request |
| timeout_val_i | input | 32 | Programmed time-out period |
| window_val_i | input | 32 | Window threshold |
| svc_done_i | input | 1 | One-cycle pulse: valid service sequence completed |
| svc_wr_i | input | 1 | Strobe: a service write was attempted |
| count_o | output | 32 | Current counter value |
| timeout_o | output | 1 | One-cycle time-out event |
| win_open_o | output | 1 | Service window is open |
| bus_err_o | output | 1 | Invalid access, reported as a bus error |
| rst_req_o | output | 1 | Invalid access, reported as a reset request |

## Verification
The bench programs the period both below and above the floor. This shows whether the floor is substituted only when the value is small. It lets the counter run out and also services it partway through, which separates reload-by-expiry from reload-by-service and catches a time-out pulse that lasts more than one cycle. In window mode it walks the counter across the threshold and sends service pulses and write strobes on both sides of it. This exposes an off-by-one in the strict compare, a service accepted while the window is closed, and a response steered to the wrong output. Runs with window mode off and with the block disabled confirm that both paths stay quiet and that the count holds.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
  typedef enum logic {
    RESP_BUS_ERR = 1'b0,
    RESP_RESET   = 1'b1
  } resp_e;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_LOAD,
    CNT_DEC
  } cnt_op_e;
endpackage

// File: rtl/wwdg_period.sv
module wwdg_period #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MIN_PERIOD = 256
) (
  input  logic [CNT_W-1:0] timeout_val_i,
  output logic [CNT_W-1:0] period_o
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_PERIOD);

  always_comb begin
    if (timeout_val_i < FLOOR) period_o = FLOOR;
    else                       period_o = timeout_val_i;
  end
endmodule

// File: rtl/wwdg_counter.sv
module wwdg_counter
  import wwdg_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             svc_ok_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o
);
  logic    en_q;
  logic    start;
  logic    expired;
  cnt_op_e op;

  assign start   = enable_i & ~en_q;
  assign expired = enable_i & ~start & ~svc_ok_i & (count_o == '0);

  always_comb begin
    if (!enable_i)                       op = CNT_HOLD;
    else if (start || svc_ok_i || expired) op = CNT_LOAD;
    else                                 op = CNT_DEC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      count_o   <= '0;
      timeout_o <= 1'b0;
    end else begin
      en_q      <= enable_i;
      timeout_o <= expired;
      unique case (op)
        CNT_LOAD: count_o <= period_i;
        CNT_DEC:  count_o <= count_o - 1'b1;
        default:  count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/wwdg_window.sv
module wwdg_window
  import wwdg_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             win_mode_i,
  input  logic             resp_sel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] window_val_i,
  input  logic             svc_wr_i,
  output logic             win_open_o,
  output logic             bus_err_o,
  output logic             rst_req_o
);
  logic  bad_wr;
  resp_e resp;

  assign win_open_o = ~win_mode_i | (count_i < window_val_i);
  assign bad_wr     = enable_i & svc_wr_i & ~win_open_o;
  assign resp       = resp_e'(resp_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_err_o <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      bus_err_o <= bad_wr & (resp == RESP_BUS_ERR);
      rst_req_o <= bad_wr & (resp == RESP_RESET);
    end
  end
endmodule

// File: rtl/wwdg_down_counter.sv
module wwdg_down_counter #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MIN_PERIOD = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             win_mode_i,
  input  logic             resp_sel_i,
  input  logic [CNT_W-1:0] timeout_val_i,
  input  logic [CNT_W-1:0] window_val_i,
  input  logic             svc_done_i,
  input  logic             svc_wr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o,
  output logic             win_open_o,
  output logic             bus_err_o,
  output logic             rst_req_o
);
  logic [CNT_W-1:0] period;
  logic             svc_ok;

  // service only counts inside the window
  assign svc_ok = svc_done_i & win_open_o;

  wwdg_period #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_period (
    .timeout_val_i(timeout_val_i),
    .period_o     (period)
  );

  wwdg_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .svc_ok_i (svc_ok),
    .period_i (period),
    .count_o  (count_o),
    .timeout_o(timeout_o)
  );

  wwdg_window #(.CNT_W(CNT_W)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .win_mode_i  (win_mode_i),
    .resp_sel_i  (resp_sel_i),
    .count_i     (count_o),
    .window_val_i(window_val_i),
    .svc_wr_i    (svc_wr_i),
    .win_open_o  (win_open_o),
    .bus_err_o   (bus_err_o),
    .rst_req_o   (rst_req_o)
  );
endmodule

// File: rtl/wwdg_down_counter_chk.sv
module wwdg_down_counter_chk #(
  parameter int unsigned CNT_W      = 32,
  parameter int unsigned MIN_PERIOD = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             win_mode_i,
  input logic             svc_wr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             timeout_o,
  input logic             win_open_o,
  input logic             bus_err_o,
  input logic             rst_req_o
);
  p_reload_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> count_o >= CNT_W'(MIN_PERIOD));

  p_single_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> $stable(count_o));

  p_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!timeout_o && !bus_err_o && !rst_req_o));

  p_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_err_o && rst_req_o));

  p_open_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_mode_i |-> win_open_o);

  p_no_err_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_mode_i || !svc_wr_i) |=> (!bus_err_o && !rst_req_o));
endmodule

bind wwdg_down_counter wwdg_down_counter_chk #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .win_mode_i(win_mode_i),
  .svc_wr_i  (svc_wr_i),
  .count_o   (count_o),
  .timeout_o (timeout_o),
  .win_open_o(win_open_o),
  .bus_err_o (bus_err_o),
  .rst_req_o (rst_req_o)
);

// File: tb/wwdg_down_counter_bench.sv
module wwdg_down_counter_bench;
  localparam int unsigned CNT_W = 32;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             enable_i = 1'b0;
  logic             win_mode_i = 1'b0;
  logic             resp_sel_i = 1'b0;
  logic [CNT_W-1:0] timeout_val_i = '0;
  logic [CNT_W-1:0] window_val_i = '0;
  logic             svc_done_i = 1'b0;
  logic             svc_wr_i = 1'b0;
  logic [CNT_W-1:0] count_o;
  logic             timeout_o;
  logic             win_open_o;
  logic             bus_err_o;
  logic             rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  wwdg_down_counter u_wwdg_down_counter (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic restart(input logic [CNT_W-1:0] tv, input logic wm);
    enable_i = 1'b0;
    step();
    timeout_val_i = tv;
    win_mode_i    = wm;
    enable_i      = 1'b1;
    step();
  endtask

  task automatic t_reset();
    chk(count_o == 0, "R10 count", count_o, 0);
    chk(!timeout_o && !bus_err_o && !rst_req_o, "R10 outputs", {timeout_o, bus_err_o, rst_req_o}, 0);
  endtask

  task automatic t_floor();
    restart(32'd5, 1'b0);
    chk(count_o == 256, "R1 floor", count_o, 256);
    restart(32'd1000, 1'b0);
    chk(count_o == 1000, "R1 above floor", count_o, 1000);
    step(37);
    chk(count_o == 963, "R2 countdown", count_o, 963);
  endtask

  task automatic t_expire();
    restart(32'd0, 1'b0);
    step(256);
    chk(count_o == 0 && !timeout_o, "R3 at zero", count_o, 0);
    step();
    chk(timeout_o == 1'b1, "R3 pulse", timeout_o, 1);
    chk(count_o == 256, "R3 reload", count_o, 256);
    step();
    chk(timeout_o == 1'b0, "R3 one cycle", timeout_o, 0);
    chk(count_o == 255, "R2 after reload", count_o, 255);
  endtask

  task automatic t_service();
    restart(32'd300, 1'b0);
    step(10);
    svc_done_i = 1'b1;
    step();
    svc_done_i = 1'b0;
    chk(count_o == 300, "R4 reload", count_o, 300);
    step();
    chk(count_o == 299, "R4 resumes", count_o, 299);
  endtask

  task automatic t_window();
    window_val_i = 32'd100;
    resp_sel_i   = 1'b0;
    restart(32'd300, 1'b1);
    chk(win_open_o == 1'b0, "R6 closed at load", win_open_o, 0);
    step(200);
    chk(count_o == 100 && !win_open_o, "R6 equal is closed", win_open_o, 0);
    svc_done_i = 1'b1;
    step();
    svc_done_i = 1'b0;
    chk(count_o == 99, "R8 closed service ignored", count_o, 99);
    chk(win_open_o == 1'b1, "R6 open below", win_open_o, 1);
    svc_wr_i = 1'b1;
    step();
    svc_wr_i = 1'b0;
    chk(!bus_err_o && !rst_req_o, "R8 open write ok", {bus_err_o, rst_req_o}, 0);
    svc_done_i = 1'b1;
    step();
    svc_done_i = 1'b0;
    chk(count_o == 300, "R4 open service", count_o, 300);
    svc_wr_i = 1'b1;
    step();
    chk(bus_err_o && !rst_req_o, "R7 bus error", {bus_err_o, rst_req_o}, 2);
    svc_wr_i = 1'b0;
    step();
    chk(!bus_err_o && !rst_req_o, "R7 one cycle", {bus_err_o, rst_req_o}, 0);
    resp_sel_i = 1'b1;
    svc_wr_i   = 1'b1;
    step();
    svc_wr_i = 1'b0;
    chk(!bus_err_o && rst_req_o, "R7 reset request", {bus_err_o, rst_req_o}, 1);
  endtask

  task automatic t_mode_off();
    win_mode_i = 1'b0;
    step();
    chk(win_open_o == 1'b1, "R9 open", win_open_o, 1);
    svc_wr_i = 1'b1;
    step();
    svc_wr_i = 1'b0;
    chk(!bus_err_o && !rst_req_o, "R9 no error", {bus_err_o, rst_req_o}, 0);
  endtask

  task automatic t_disabled();
    logic [CNT_W-1:0] held;
    win_mode_i = 1'b1;
    enable_i   = 1'b0;
    step();
    held = count_o;
    step(5);
    chk(count_o == held, "R5 hold", count_o, held);
    svc_wr_i = 1'b1;
    step();
    svc_wr_i = 1'b0;
    chk(!bus_err_o && !rst_req_o && !timeout_o, "R5 quiet", {bus_err_o, rst_req_o}, 0);
    timeout_val_i = 32'd700;
    enable_i      = 1'b1;
    step();
    chk(count_o == 700, "R5 enable loads", count_o, 700);
  endtask

  initial begin
    step(2);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_floor();
    t_expire();
    t_service();
    t_window();
    t_mode_off();
    t_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule